// File: doc/BRIEF.md
# Six-Bit RGB Pixel Capture Writer

This block sits behind an external RGB video port and turns the incoming pixel stream into 18-bit write transactions for a display RAM. The port delivers a dot clock, active-low vertical and horizontal sync, a data-enable qualifier and an 18-bit data bus. In the narrow configuration only the low six bus lines carry data, and three successive beats make up one pixel. In the wide configuration each enabled beat already is a whole pixel.

The block owns the RAM write address. At every vertical sync falling edge it loads a start address supplied by the surrounding register logic, advances by one for each pixel written and wraps to zero after a programmable last address. Once a frame's worth of pixels has been written it stays in a front-porch state and drops all further beats until the next vertical sync. Each finished pixel produces a single write strobe, with no wait or handshake, because the RAM side accepts a write on every cycle.

The block runs entirely on the dot clock. Every timing statement below counts rising edges of `clk`.

Top module: `rgb_capture_writer`

## Requirements
- R1: With NARROW=1, three enabled beats taken from `pix_bus[5:0]` form one pixel. The first beat lands in bits [17:12], the second in [11:6] and the third in [5:0]. Bus bits [17:6] are ignored, and exactly one write is issued per three beats.
- R2: With NARROW=0, every enabled beat writes `pix_bus[17:0]` unchanged as one pixel.
- R3: A cycle with `hsync_n` low discards the beat and restarts beat assembly, so the next three enabled beats form a complete pixel.
- R4: A cycle with `enable` low discards the beat and drops any partly assembled pixel. Assembly restarts at the next enabled beat.
- R5: A cycle in which `vsync_n` is sampled low after having been sampled high loads the address from `start_addr` and starts a new frame, even in the middle of a frame. The beat in that cycle is discarded.
- R6: The address advances by one after each written pixel and goes from LAST_ADDR to zero.
- R7: After FRAME_PIXELS writes in a frame, no write occurs until the next vertical sync falling edge.
- R8: `wr_en` is high for exactly one cycle, the cycle after the edge that captured the completing beat, with `wr_addr` and `wr_data` valid in that same cycle.
- R9: After reset, all outputs are zero and no write occurs before the first vertical sync falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock; beats are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_n | input | 1 | Vertical sync, active low |
| hsync_n | input | 1 | Horizontal sync, active low |
| enable | input | 1 | Data-enable qualifier for the current beat |
| pix_bus | input | 18 | Pixel data bus; only [5:0] is used when NARROW=1 |
| start_addr | input | ADDR_W | Address loaded at each vertical sync falling edge |
| wr_en | output | 1 | One-cycle RAM write strobe |
| wr_addr | output | ADDR_W | RAM write address |
| wr_data | output | 18 | Assembled 18-bit pixel |

## Verification
The assertions check several rules on every cycle. The beat phase returns to zero after any sync, disable or frame-start cycle. The address follows `start_addr` after a sync edge, and it holds still in front porch. The wrap from the last address goes to zero. A write never follows a disabled beat, and in narrow mode no two writes are adjacent. Only the bench scenarios can show that the correct beats end up in the correct bit fields and that partial pixels are dropped rather than merged. They also show that a frame stops after exactly FRAME_PIXELS writes and that each write lands on the predicted cycle and address.

// File: rtl/rgbcw_pkg.sv
package rgbcw_pkg;
   localparam int PIX_W  = 18;
   localparam int BEAT_W = 6;
   localparam int BEATS_NARROW = PIX_W / BEAT_W;

   typedef logic [PIX_W-1:0]  pixel_t;
   typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/rgbcw_sync_edge.sv
module rgbcw_sync_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_n,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sync_n;
   end

   assign fall = prev_q & ~sync_n;
endmodule

// File: rtl/rgbcw_beat_asm.sv
module rgbcw_beat_asm
   import rgbcw_pkg::*;
#(
   parameter bit NARROW = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clear,
   input  logic   take,
   input  pixel_t din,
   output logic   done,
   output pixel_t pixel
);
   generate
      if (NARROW) begin : g_narrow
         localparam int LAST_PH = BEATS_NARROW - 1;
         logic [1:0] phase_q;
         logic [PIX_W-BEAT_W-1:0] hold_q;
         logic unused_hi;

         assign unused_hi = ^din[PIX_W-1:BEAT_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
               hold_q  <= '0;
            end else if (clear) begin
               phase_q <= '0;
            end else if (take) begin
               if (phase_q == 2'(LAST_PH)) phase_q <= '0;
               else                        phase_q <= phase_q + 2'd1;
               if (phase_q == 2'd0) hold_q[PIX_W-BEAT_W-1:BEAT_W] <= din[BEAT_W-1:0];
               if (phase_q == 2'd1) hold_q[BEAT_W-1:0]            <= din[BEAT_W-1:0];
            end
         end

         assign done  = take & ~clear & (phase_q == 2'(LAST_PH));
         assign pixel = {hold_q, din[BEAT_W-1:0]};

         // R3 R4
         phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> (phase_q == 2'd0));
         // R1
         phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            phase_q <= 2'(LAST_PH));
         // R1
         phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> (phase_q == 2'd0));
      end else begin : g_wide
         logic unused_clk;
         assign unused_clk = clk ^ rst_n ^ clear;
         assign done  = take;
         assign pixel = din;
      end
   endgenerate
endmodule

// File: rtl/rgbcw_addr_gen.sv
module rgbcw_addr_gen #(
   parameter int ADDR_W       = 17,
   parameter int LAST_ADDR    = 76799,
   parameter int FRAME_PIXELS = 76800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              porch
);
   localparam int CNT_W = (FRAME_PIXELS > 1) ? $clog2(FRAME_PIXELS) : 1;
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);
   localparam logic [CNT_W-1:0]  LAST_C = CNT_W'(FRAME_PIXELS - 1);

   generate
      if (LAST_ADDR < 0 || LAST_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_last
         $error("LAST_ADDR does not fit in ADDR_W bits");
      end
      if (FRAME_PIXELS < 1) begin : g_bad_frame
         $error("FRAME_PIXELS must be at least one");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         cnt_q <= '0;
         porch <= 1'b1;
      end else if (reload) begin
         addr  <= start_addr;
         cnt_q <= '0;
         porch <= 1'b0;
      end else if (step && !porch) begin
         addr <= (addr == LAST_A) ? '0 : addr + 1'b1;
         if (cnt_q == LAST_C) begin
            cnt_q <= '0;
            porch <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R5
   reload_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (addr == $past(start_addr)) && !porch);
   // R7
   porch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (porch && !reload) |=> porch && $stable(addr));
   // R6
   addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !porch && !reload && addr == LAST_A) |=> (addr == '0));
endmodule

// File: rtl/rgb_capture_writer.sv
module rgb_capture_writer
   import rgbcw_pkg::*;
#(
   parameter int ADDR_W       = 17,
   parameter int LAST_ADDR    = 76799,
   parameter int FRAME_PIXELS = 76800,
   parameter bit NARROW       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_n,
   input  logic              hsync_n,
   input  logic              enable,
   input  logic [17:0]       pix_bus,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [17:0]       wr_data
);
   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W out of range");
      end
   endgenerate

   logic              vfall;
   logic              porch;
   logic              clear;
   logic              take;
   logic              done;
   pixel_t            pixel;
   logic [ADDR_W-1:0] addr;

   rgbcw_sync_edge u_vedge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_n (vsync_n),
      .fall   (vfall)
   );

   assign clear = vfall | ~hsync_n | ~enable;
   assign take  = enable & hsync_n & ~vfall & ~porch;

   rgbcw_beat_asm #(.NARROW(NARROW)) u_beats (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .take  (take),
      .din   (pix_bus),
      .done  (done),
      .pixel (pixel)
   );

   rgbcw_addr_gen #(
      .ADDR_W       (ADDR_W),
      .LAST_ADDR    (LAST_ADDR),
      .FRAME_PIXELS (FRAME_PIXELS)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload     (vfall),
      .start_addr (start_addr),
      .step       (done),
      .addr       (addr),
      .porch      (porch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= done;
         if (done) begin
            wr_addr <= addr;
            wr_data <= pixel;
         end
      end
   end

   // R4 R3
   write_from_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(enable) && $past(hsync_n));
   // R7
   write_outside_porch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$past(porch));

   generate
      if (NARROW) begin : g_narrow_chk
         // R1
         no_adjacent_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> !wr_en);
      end
   endgenerate
endmodule

// File: tb/rgb_capture_writer_bench.sv
`timescale 1ns/1ps
module rgb_capture_writer_bench;
   localparam int AW   = 4;
   localparam int LAST = 9;
   localparam int FP   = 6;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          vs [2];
   logic          hs [2];
   logic          en [2];
   logic [17:0]   bus [2];
   logic [AW-1:0] sa [2];
   logic          we [2];
   logic [AW-1:0] wa [2];
   logic [17:0]   wd [2];

   rgb_capture_writer #(.ADDR_W(AW), .LAST_ADDR(LAST), .FRAME_PIXELS(FP), .NARROW(1'b1))
   u_rgb_capture_writer (
      .clk(clk), .rst_n(rst_n), .vsync_n(vs[0]), .hsync_n(hs[0]), .enable(en[0]),
      .pix_bus(bus[0]), .start_addr(sa[0]), .wr_en(we[0]), .wr_addr(wa[0]), .wr_data(wd[0]));

   rgb_capture_writer #(.ADDR_W(AW), .LAST_ADDR(LAST), .FRAME_PIXELS(FP), .NARROW(1'b0))
   u_rgb_capture_writer_wide (
      .clk(clk), .rst_n(rst_n), .vsync_n(vs[1]), .hsync_n(hs[1]), .enable(en[1]),
      .pix_bus(bus[1]), .start_addr(sa[1]), .wr_en(we[1]), .wr_addr(wa[1]), .wr_data(wd[1]));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int errors = 0;
   int checks = 0;
   bit done_run = 1'b0;

   logic [AW-1:0] e_addr [2][64];
   logic [17:0]   e_data [2][64];
   int            e_cyc  [2][64];
   int            wp [2];
   int            rp [2];
   int            nxt [2];
   string         tag [2];

   function automatic logic [5:0] beat_of(int k, int j);
      return 6'((k * (7 - 2 * j) + j + 1) & 63);
   endfunction

   function automatic logic [17:0] narrow_pix(int k);
      return {beat_of(k, 0), beat_of(k, 1), beat_of(k, 2)};
   endfunction

   function automatic logic [17:0] wide_pix(int k);
      return 18'((k * 1237 + 5) & 18'h3FFFF);
   endfunction

   task automatic push(int m, logic [17:0] p);
      e_addr[m][wp[m]] = AW'(nxt[m]);
      e_data[m][wp[m]] = p;
      e_cyc[m][wp[m]]  = cyc + 1;
      wp[m]  = (wp[m] + 1) % 64;
      nxt[m] = (nxt[m] + 1) % (LAST + 1);
   endtask

   task automatic idle(int m);
      @(negedge clk);
      vs[m] = 1'b1; hs[m] = 1'b1; en[m] = 1'b0;
   endtask

   task automatic vfall(int m, int start);
      @(negedge clk);
      sa[m] = AW'(start); vs[m] = 1'b0; en[m] = 1'b1; hs[m] = 1'b1;
      bus[m] = 18'h3FFFF;
      nxt[m] = start;
      @(negedge clk);
      vs[m] = 1'b1; en[m] = 1'b0;
   endtask

   task automatic hline(int m);
      @(negedge clk);
      hs[m] = 1'b0; en[m] = 1'b0;
   endtask

   task automatic one_beat(int m, int k, int j);
      @(negedge clk);
      hs[m] = 1'b1; en[m] = 1'b1;
      bus[m] = (m == 0) ? {12'(k * 91 + 13), beat_of(k, j)} : wide_pix(k);
   endtask

   task automatic pix(int m, int k, bit expect_w);
      if (m == 0) begin
         for (int j = 0; j < 3; j++) one_beat(m, k, j);
         if (expect_w) push(m, narrow_pix(k));
      end else begin
         one_beat(m, k, 0);
         if (expect_w) push(m, wide_pix(k));
      end
   endtask

   task automatic drain(int m);
      idle(m); idle(m); idle(m);
      checks++;
      if (rp[m] != wp[m]) begin
         errors++;
         $display("FAIL %s missing write: pending=%0d expected=0", tag[m], (wp[m] - rp[m] + 64) % 64);
         rp[m] = wp[m];
      end
   endtask

   always @(negedge clk) begin
      for (int m = 0; m < 2; m++) begin
         if (rst_n && we[m]) begin
            checks++;
            if (rp[m] == wp[m]) begin
               errors++;
               $display("FAIL %s/R7 unexpected write: addr=%0d data=%h expected no write",
                        tag[m], wa[m], wd[m]);
            end else begin
               if (e_cyc[m][rp[m]] != cyc) begin
                  errors++;
                  $display("FAIL %s/R8 write cycle: actual=%0d expected=%0d", tag[m], cyc, e_cyc[m][rp[m]]);
               end else if (wa[m] != e_addr[m][rp[m]]) begin
                  errors++;
                  $display("FAIL %s/R6 address: actual=%0d expected=%0d", tag[m], wa[m], e_addr[m][rp[m]]);
               end else if (wd[m] != e_data[m][rp[m]]) begin
                  errors++;
                  $display("FAIL %s/%s data: actual=%h expected=%h", tag[m],
                           (m == 0) ? "R1" : "R2", wd[m], e_data[m][rp[m]]);
               end
               rp[m] = (rp[m] + 1) % 64;
            end
         end
      end
   end

   task automatic chk_zero(int m);
      checks++;
      if (we[m] !== 1'b0 || wa[m] !== '0 || wd[m] !== '0) begin
         errors++;
         $display("FAIL R9 reset outputs: we=%b addr=%0d data=%h expected 0/0/0", we[m], wa[m], wd[m]);
      end
   endtask

   initial begin
      for (int m = 0; m < 2; m++) begin
         vs[m] = 1'b1; hs[m] = 1'b1; en[m] = 1'b0; bus[m] = '0; sa[m] = '0;
         wp[m] = 0; rp[m] = 0; nxt[m] = 0; tag[m] = "R9";
      end
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_zero(0);
      chk_zero(1);
      rst_n = 1'b1;

      // R9: beats before the first vertical sync produce nothing
      pix(0, 40, 1'b0); pix(0, 41, 1'b0);
      drain(0);

      // R5 frame start at 8; R1 field order; R6 wraps 9 -> 0
      tag[0] = "R5"; vfall(0, 8);
      tag[0] = "R1"; hline(0); pix(0, 1, 1'b1); pix(0, 2, 1'b1);
      // R4: two beats then enable low, the partial pixel is dropped
      tag[0] = "R4"; hline(0); one_beat(0, 90, 0); one_beat(0, 90, 1);
      idle(0); pix(0, 3, 1'b1);
      // R3: a beat, then hsync low with enable high, then a full pixel
      tag[0] = "R3"; hline(0); one_beat(0, 91, 0);
      @(negedge clk); hs[0] = 1'b0; en[0] = 1'b1;
      pix(0, 4, 1'b1);
      tag[0] = "R6"; hline(0); pix(0, 5, 1'b1); pix(0, 6, 1'b1);
      // R7: the frame is full, extra pixels are dropped
      tag[0] = "R7"; hline(0); pix(0, 7, 1'b0); pix(0, 8, 1'b0);
      drain(0);

      // R5: reload in the middle of a frame
      tag[0] = "R5"; vfall(0, 3); hline(0);
      pix(0, 10, 1'b1); pix(0, 11, 1'b1);
      vfall(0, 5);
      for (int k = 12; k < 18; k++) pix(0, k, 1'b1);
      tag[0] = "R7"; pix(0, 18, 1'b0);
      drain(0);

      // R9 on the wide instance, then R2 back-to-back pixels
      tag[1] = "R9"; pix(1, 50, 1'b0); drain(1);
      tag[1] = "R2"; vfall(1, 7); hline(1);
      for (int k = 0; k < 6; k++) pix(1, k, 1'b1);
      tag[1] = "R7"; pix(1, 6, 1'b0); pix(1, 7, 1'b0);
      drain(1);
      tag[1] = "R4"; vfall(1, 2); pix(1, 20, 1'b1); idle(1); pix(1, 21, 1'b1);
      drain(1);

      done_run = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done_run) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule